// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular list of transmit descriptors that software keeps in shared memory and turns each descriptor into a run of bytes on a byte-stream port feeding a MAC transmitter. Each descriptor is four 32-bit words on a 16-byte boundary. Word 0 carries the hand-over flag, the frame segment markers, a wrap marker and the byte count. Word 3 carries the buffer start address, which may have any byte alignment. Words 1 and 2 are never read.

Software sets the ring base and raises the transmit enable. It hands descriptors over by setting their hand-over flag, then pulses the poll-demand input. The engine then fetches descriptors from its current pointer, one after another. For each one it streams the buffer and writes word 0 back with the hand-over flag cleared. It stops at the first descriptor that it does not own and waits there for the next poll demand. Memory is reached through a single word-wide port that has at most one access in flight. A read is answered by a read-valid strobe.

Top module: `txring_engine`

## Requirements
- R1: Through reset and in the cycles after it, `mem_req` and `tx_valid` stay low, and the descriptor pointer equals `ring_base`.
- R2: A `poll_kick` pulse while `dma_en` is high starts a read of word 0 at the current pointer. A pulse while `dma_en` is low is dropped: raising `dma_en` later causes no memory access.
- R3: If word 0 bit 31 (hand-over flag) reads as 0, the engine goes idle without writing and leaves the pointer unchanged. The next poll demand reads that same address again.
- R4: For an owned descriptor, the engine reads word 3 at pointer+12. It then sends exactly the count in word 0 bits 13:0, taking bytes from the word-3 address upward with no padding. Byte lane k of a memory word is bits 8k+7:8k (little-endian), and the start address may have any alignment.
- R5: `tx_sof` is high on the first byte of a descriptor only when word 0 bit 29 is set. `tx_eof` is high on its last byte only when word 0 bit 28 is set. Neither marker is ever high while `tx_valid` is low.
- R6: After the last byte has been accepted, word 0 is written back to the pointer address with bit 31 cleared and every other bit unchanged.
- R7: After the write-back the next descriptor is fetched from pointer+16, or from `ring_base` when word 0 bit 15 (wrap marker) is set. The walk continues until a descriptor that is not owned is reached.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_sof` and `tx_eof` hold their values.
- R9: When `dma_en` goes low, the engine stops one cycle later: no memory request and no stream byte. The descriptor in progress is not written back.
- R10: A `soft_reset` pulse stops the engine and reloads the pointer with `ring_base`.
- R11: A descriptor with a byte count of 0 sends no bytes and is still written back and passed.
- R12: A memory request is never raised in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Ring base byte address (16-byte aligned) |
| dma_en | input | 1 | Transmit DMA enable; low halts the engine |
| poll_kick | input | 1 | Poll-demand pulse |
| soft_reset | input | 1 | Pulse: halt and reload pointer to base |
| mem_req | output | 1 | Memory access request, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read data strobe |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
The bench builds the engine with a 16-bit address width and a 4 KB word memory model that answers one cycle after each request. This makes room for a three-descriptor ring with a wrap marker, a split frame, buffers that start on every byte lane, and a zero-length descriptor. A pseudo-random `tx_ready` pattern exercises stalls on every descriptor. The bench also drops the enable in the middle of a 40-byte buffer and checks that no write-back follows. It then moves the base and uses the soft reset to confirm that the next fetch starts at the new base.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int OWN_B  = 31;
  localparam int FS_B   = 29;
  localparam int LS_B   = 28;
  localparam int WRAP_B = 15;
  localparam int SZ_W   = 14;
  localparam int BUF_OFS = 12;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_W0, S_RD3, S_W3, S_RDB, S_WB_B, S_SEND, S_WB, S_NEXT
  } st_t;
endpackage

// File: rtl/txring_ring_ptr.sv
module txring_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic          reload,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  localparam int SW = AW - 4;
  logic [SW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst || reload) slot_q <= base[AW-1:4];
    else if (advance)  slot_q <= wrap ? base[AW-1:4] : slot_q + 1'b1;
  end

  assign ptr = {slot_q, 4'b0000};
endmodule

// File: rtl/txring_byte_emit.sv
module txring_byte_emit (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [1:0]  lane,
  input  logic [2:0]  nbytes,
  input  logic        sof_in,
  input  logic        eof_in,
  input  logic        ready,
  output logic        valid,
  output logic [7:0]  data,
  output logic        sof,
  output logic        eof
);
  logic [31:0] sh_q;
  logic [2:0]  left_q;
  logic        sof_q, eof_q, vld_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      sh_q <= '0; left_q <= '0; sof_q <= 1'b0; eof_q <= 1'b0; vld_q <= 1'b0;
    end else if (load) begin
      sh_q   <= word >> {lane, 3'b000};
      left_q <= nbytes;
      vld_q  <= (nbytes != 3'd0);
      sof_q  <= sof_in;
      eof_q  <= eof_in;
    end else if (vld_q && ready) begin
      sh_q   <= sh_q >> 8;
      left_q <= left_q - 1'b1;
      sof_q  <= 1'b0;
      if (left_q == 3'd1) vld_q <= 1'b0;
    end
  end

  assign valid = vld_q;
  assign data  = sh_q[7:0];
  assign sof   = sof_q;
  assign eof   = eof_q && (left_q == 3'd1);
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ring_base,
  input  logic          dma_en,
  input  logic          poll_kick,
  input  logic          soft_reset,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_rvalid,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_sof,
  output logic          tx_eof,
  input  logic          tx_ready
);
  st_t             state;
  logic [31:0]     w0_q;
  logic [AW-1:0]   buf_q;
  logic [SZ_W-1:0] cnt_q;
  logic            kick_q;
  logic [AW-1:0]   ptr;
  logic            halt;
  logic [SZ_W-1:0] size, remain;
  logic [AW-1:0]   byte_addr;
  logic [1:0]      lane;
  logic [2:0]      room, nb;
  logic            em_busy, em_load;

  assign halt      = !dma_en || soft_reset;
  assign size      = w0_q[SZ_W-1:0];
  assign byte_addr = buf_q + AW'(cnt_q);
  assign lane      = byte_addr[1:0];
  assign remain    = size - cnt_q;
  assign room      = 3'd4 - {1'b0, lane};
  assign nb        = (remain < SZ_W'(room)) ? remain[2:0] : room;
  assign em_load   = (state == S_WB_B) && mem_rvalid;

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      state  <= S_IDLE;
      kick_q <= 1'b0;
      w0_q   <= '0;
      buf_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (poll_kick) kick_q <= 1'b1;
      case (state)
        S_IDLE: if (kick_q || poll_kick) begin
          state  <= S_RD0;
          kick_q <= 1'b0;
        end
        S_RD0: state <= S_W0;
        S_W0: if (mem_rvalid) begin
          w0_q <= mem_rdata;
          if (!mem_rdata[OWN_B])               state <= S_IDLE;
          else if (mem_rdata[SZ_W-1:0] == '0)  state <= S_WB;
          else                                 state <= S_RD3;
        end
        S_RD3: state <= S_W3;
        S_W3: if (mem_rvalid) begin
          buf_q <= mem_rdata[AW-1:0];
          cnt_q <= '0;
          state <= S_RDB;
        end
        S_RDB: state <= S_WB_B;
        S_WB_B: if (mem_rvalid) begin
          cnt_q <= cnt_q + SZ_W'(nb);
          state <= S_SEND;
        end
        S_SEND: if (!em_busy) state <= (cnt_q == size) ? S_WB : S_RDB;
        S_WB:   state <= S_NEXT;
        S_NEXT: state <= S_RD0;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (state == S_RD0) || (state == S_RD3) || (state == S_RDB) || (state == S_WB);
    mem_we    = (state == S_WB);
    mem_wdata = w0_q & ~(32'h1 << OWN_B);
    case (state)
      S_RD3:   mem_addr = ptr + AW'(BUF_OFS);
      S_RDB:   mem_addr = {byte_addr[AW-1:2], 2'b00};
      default: mem_addr = ptr;
    endcase
  end

  txring_ring_ptr #(.AW(AW)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .base    (ring_base),
    .reload  (soft_reset),
    .advance (state == S_NEXT),
    .wrap    (w0_q[WRAP_B]),
    .ptr     (ptr)
  );

  txring_byte_emit u_emit (
    .clk    (clk),
    .rst    (rst),
    .flush  (halt),
    .load   (em_load),
    .word   (mem_rdata),
    .lane   (lane),
    .nbytes (nb),
    .sof_in (w0_q[FS_B] && (cnt_q == '0)),
    .eof_in (w0_q[LS_B] && ((cnt_q + SZ_W'(nb)) == size)),
    .ready  (tx_ready),
    .valid  (em_busy),
    .data   (tx_data),
    .sof    (tx_sof),
    .eof    (tx_eof)
  );

  assign tx_valid = em_busy;
endmodule

// File: rtl/txring_engine_chk.sv
module txring_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          dma_en,
  input logic          soft_reset,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_sof,
  input logic          tx_eof,
  input logic          tx_ready
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs quiet in the cycle after a reset edge
  always_ff @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_quiet: assert (!mem_req && !tx_valid)
        else $error("a_r1_reset_quiet");
    end
  end

  a_r5_marks_need_valid: assert property (@(posedge clk) disable iff (rst)
    (tx_sof || tx_eof) |-> tx_valid);

  a_r6_wb_clears_own: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (!mem_wdata[31] && mem_addr[3:0] == 4'h0));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && dma_en && !soft_reset)
      |=> (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)));

  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> (!mem_req && !tx_valid));

  a_r10_sreset_quiet: assert property (@(posedge clk) disable iff (rst)
    soft_reset |=> (!mem_req && !tx_valid));

  a_r12_single_access: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
endmodule

bind txring_engine txring_engine_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dma_en     (dma_en),
  .soft_reset (soft_reset),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .tx_data    (tx_data),
  .tx_valid   (tx_valid),
  .tx_sof     (tx_sof),
  .tx_eof     (tx_eof),
  .tx_ready   (tx_ready)
);

// File: tb/txring_engine_bench.sv
module txring_engine_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ring_base = 16'h0100;
  logic          dma_en = 1'b0;
  logic          poll_kick = 1'b0;
  logic          soft_reset = 1'b0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          mem_rvalid = 1'b0;
  logic [7:0]    tx_data;
  logic          tx_valid, tx_sof, tx_eof;
  logic          tx_ready = 1'b1;

  always #4 clk = ~clk;

  txring_engine #(.AW(AW)) u_txring_engine (
    .clk(clk), .rst(rst), .ring_base(ring_base), .dma_en(dma_en),
    .poll_kick(poll_kick), .soft_reset(soft_reset),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .tx_ready(tx_ready)
  );

  // memory model: one-cycle read latency
  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else begin
        mem_rdata  <= mem[mem_addr[11:2]];
        mem_rvalid <= 1'b1;
      end
    end
  end

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[11:4] ^ 8'h5A;
  endfunction

  // scoreboard
  logic [9:0] expq[$];
  task automatic put_desc(input logic [15:0] a, input bit own, input bit fs, input bit ls,
                          input bit wrp, input int size, input logic [15:0] bufa);
    logic [31:0] w0;
    w0 = {own, 1'b0, fs, ls, 12'h0, wrp, 1'b0, 14'(size)};
    w0[22:16] = 7'h2B; // spare bits that write-back must keep
    mem[a[11:2]]     = w0;
    mem[a[11:2] + 3] = {16'h0, bufa};
    if (own)
      for (int i = 0; i < size; i++)
        expq.push_back({fs && i == 0, ls && i == size - 1, pat(bufa + 16'(i))});
  endtask

  // monitor
  logic [15:0] lfsr = 16'hACE1;
  bit          prev_stall = 0;
  logic [9:0]  prev_out;
  int          hs_cnt = 0, rd_cnt = 0, cnt130 = 0, cnt100 = 0;
  bit          armed = 0, got_first = 0;
  logic [15:0] first_addr;

  always @(negedge clk) begin
    lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = lfsr[0] | lfsr[1];
    if (!rst && mem_req && !mem_we) begin
      rd_cnt++;
      if (mem_addr == 16'h0130) cnt130++;
      if (mem_addr == 16'h0100) cnt100++;
      if (armed && !got_first) begin first_addr = mem_addr; got_first = 1; end
    end
    if (prev_stall && dma_en)
      chk(tx_valid && {tx_sof, tx_eof, tx_data} == prev_out, "R8 hold",
          {tx_valid, tx_sof, tx_eof, tx_data}, {1'b1, prev_out});
    if (!rst && tx_valid && tx_ready) begin
      hs_cnt++;
      if (expq.size() == 0) chk(0, "R4 unexpected byte", {tx_sof, tx_eof, tx_data}, 0);
      else begin
        logic [9:0] e;
        e = expq.pop_front();
        chk({tx_sof, tx_eof, tx_data} == e, "R4/R5 byte", {tx_sof, tx_eof, tx_data}, e);
      end
    end
    prev_stall = !rst && tx_valid && !tx_ready && dma_en;
    prev_out   = {tx_sof, tx_eof, tx_data};
  end

  task automatic kick();
    @(negedge clk); poll_kick = 1'b1;
    @(negedge clk); poll_kick = 1'b0;
  endtask

  task automatic wait_quiet();
    int quiet = 0;
    while (quiet < 30) begin
      @(negedge clk);
      if (mem_req || tx_valid) quiet = 0; else quiet++;
    end
  endtask

  function automatic logic [31:0] own_cleared(input logic [31:0] w);
    return w & 32'h7FFF_FFFF;
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] w0a, w1a, w2a;
    int rd0, hs0;
    for (int w = 0; w < 1024; w++)
      for (int k = 0; k < 4; k++)
        mem[w][8*k +: 8] = pat(16'(w * 4 + k));

    repeat (4) @(negedge clk);
    chk(!mem_req && !tx_valid, "R1 in reset", {mem_req, tx_valid}, 0);
    rst = 1'b0;
    dma_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_req && !tx_valid, "R1 after reset", {mem_req, tx_valid}, 0);

    // R4 R5 R6 R7: three-descriptor ring with wrap, split frame, odd alignments
    put_desc(16'h0100, 1, 1, 1, 0, 5, 16'h0203);
    put_desc(16'h0110, 1, 1, 0, 0, 3, 16'h0300);
    put_desc(16'h0120, 1, 0, 1, 1, 6, 16'h0401);
    put_desc(16'h0130, 1, 1, 1, 0, 4, 16'h0500);
    expq.delete();
    put_desc(16'h0100, 1, 1, 1, 0, 5, 16'h0203);
    put_desc(16'h0110, 1, 1, 0, 0, 3, 16'h0300);
    put_desc(16'h0120, 1, 0, 1, 1, 6, 16'h0401);
    w0a = mem[16'h0100 >> 2]; w1a = mem[16'h0110 >> 2]; w2a = mem[16'h0120 >> 2];
    armed = 1; got_first = 0;
    kick();
    wait_quiet();
    chk(got_first && first_addr == 16'h0100, "R1 R2 first fetch at base", first_addr, 16'h0100);
    chk(expq.size() == 0, "R4 all bytes sent", expq.size(), 0);
    chk(mem[16'h0100 >> 2] == own_cleared(w0a), "R6 wb desc0", mem[16'h0100 >> 2], own_cleared(w0a));
    chk(mem[16'h0110 >> 2] == own_cleared(w1a), "R6 wb desc1", mem[16'h0110 >> 2], own_cleared(w1a));
    chk(mem[16'h0120 >> 2] == own_cleared(w2a), "R6 wb desc2", mem[16'h0120 >> 2], own_cleared(w2a));
    chk(cnt130 == 0, "R7 wrap skips base+48", cnt130, 0);
    chk(cnt100 == 2, "R3 R7 stop at unowned base", cnt100, 2);
    chk(mem[16'h0130 >> 2][31] == 1'b1, "R7 untouched desc", mem[16'h0130 >> 2][31], 1);

    // R11: zero-length descriptor
    put_desc(16'h0100, 1, 1, 1, 0, 0, 16'h0600);
    w0a = mem[16'h0100 >> 2];
    hs0 = hs_cnt;
    kick();
    wait_quiet();
    chk(hs_cnt == hs0, "R11 no bytes", hs_cnt - hs0, 0);
    chk(mem[16'h0100 >> 2] == own_cleared(w0a), "R11 written back", mem[16'h0100 >> 2], own_cleared(w0a));

    // R3: pointer stayed on the unowned slot at base+16
    put_desc(16'h0110, 1, 1, 1, 1, 2, 16'h0602);
    armed = 1; got_first = 0;
    kick();
    wait_quiet();
    chk(first_addr == 16'h0110, "R3 refetch same slot", first_addr, 16'h0110);
    chk(expq.size() == 0, "R4 two-byte frame", expq.size(), 0);

    // R2: poll while disabled is dropped
    put_desc(16'h0100, 1, 1, 1, 0, 3, 16'h0640);
    expq.delete();
    @(negedge clk); dma_en = 1'b0;
    rd0 = rd_cnt;
    kick();
    @(negedge clk); dma_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(rd_cnt == rd0, "R2 kick while disabled", rd_cnt - rd0, 0);

    // R10: soft reset reloads pointer from a new base
    ring_base = 16'h0180;
    @(negedge clk); soft_reset = 1'b1;
    @(negedge clk); soft_reset = 1'b0;
    put_desc(16'h0180, 1, 1, 1, 1, 7, 16'h0611);
    armed = 1; got_first = 0;
    kick();
    wait_quiet();
    chk(first_addr == 16'h0180, "R10 fetch at new base", first_addr, 16'h0180);
    chk(expq.size() == 0, "R4 seven-byte frame", expq.size(), 0);

    // R9: drop enable mid-buffer
    put_desc(16'h0180, 1, 1, 1, 1, 40, 16'h0700);
    hs0 = hs_cnt;
    kick();
    while (hs_cnt < hs0 + 10) @(negedge clk);
    dma_en = 1'b0;
    @(negedge clk);
    chk(!tx_valid && !mem_req, "R9 stop in one cycle", {tx_valid, mem_req}, 0);
    rd0 = rd_cnt;
    repeat (10) @(negedge clk);
    chk(rd_cnt == rd0 && !tx_valid, "R9 stays quiet", rd_cnt - rd0, 0);
    chk(mem[16'h0180 >> 2][31] == 1'b1, "R9 no write-back", mem[16'h0180 >> 2][31], 1);
    expq.delete();
    dma_en = 1'b1;
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule